// File: doc/BRIEF.md
# Floppy Data-Rate Select Register

This block is the write-only rate and precompensation control register in a floppy disk controller's host interface. Host writes to its I/O offset set the media data rate, pick a write-precompensation delay, request manual low power and trigger a software reset. A companion configuration-control register at a second offset also writes the data-rate field. Whichever of the two was written last sets the rate.

The block turns the stored precompensation code into a delay expressed in steps of 41.67 ns. A code of zero gives a default delay that depends on the data rate. The block keeps a manual low-power state and drives a power-down signal to the clock and data-separator logic. It leaves that state when the host touches the data or status register, or when the host issues a software reset. A software-reset request gives a one-clock pulse for the rest of the controller. The register's own contents are never cleared by that pulse.

Top module: `fdc_rate_reg`

## Requirements
- R1: After the asynchronous reset, rate_o is 2'b10 (250 kbps), precomp_o is 3'b000, pc_step_o is 3, and pwr_down_o and sw_rst_o are 0. This is the value 02h.
- R2: A write with wr_en_i high and addr_i equal to the rate offset (default 4) loads rate_o from wdata_i[1:0] and precomp_o from wdata_i[4:2]. Both outputs change one clock after the write.
- R3: A write to the configuration offset (default 7) loads rate_o from wdata_i[1:0] one clock later and leaves precomp_o unchanged. The rate follows whichever of the two registers was written last.
- R4: A cycle with wr_en_i low, or with any other offset, leaves rate_o and precomp_o unchanged.
- R5: A rate-register write with wdata_i[7]=1 drives sw_rst_o high for exactly the next clock. The other fields of that same write still load. Nothing is cleared, and bit 7 is not stored.
- R6: A rate-register write with wdata_i[6]=1 raises pwr_down_o one clock later. pwr_down_o then stays high through later rate-register writes with bit 6 at 0 and through configuration-register writes.
- R7: While in low power, an access strobe on data_acc_i or stat_acc_i drops pwr_down_o in the same cycle. It stays low afterwards.
- R8: A software-reset write drops pwr_down_o in the same cycle and ends low power. A write with both bit 6 and bit 7 set does not enter low power. An access in the same cycle as a bit-6 write also keeps the block out of low power.
- R9: pc_step_o maps precomp_o as follows:
  - 3'b111 gives 0.
  - 3'b001 through 3'b110 give the code value.
  - 3'b000 gives 1 when rate_o is 2'b11 (1 Mbps) and 3 for every other rate.
- R10: wdata_i[5] has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous hardware reset, active low |
| wr_en_i | input | 1 | Host write strobe, one cycle |
| addr_i | input | ADDR_W | Register offset within the controller |
| wdata_i | input | 8 | Host write data |
| data_acc_i | input | 1 | Access strobe of the data register |
| stat_acc_i | input | 1 | Access strobe of the main status register |
| rate_o | output | 2 | Effective data-rate code |
| precomp_o | output | 3 | Stored precompensation code |
| pc_step_o | output | 3 | Precompensation delay in 41.67 ns steps |
| pwr_down_o | output | 1 | Power-down to clock and data-separator logic |
| sw_rst_o | output | 1 | Software-reset pulse for the rest of the controller |

## Verification
The bench alternates writes between the two offsets. A design that let the configuration write also touch the precompensation field, or that gave one register a fixed priority, would show a wrong rate or code after the other register's write. Low power is entered, then held through writes with bit 6 clear. That catches a design that treats bit 6 as a level instead of a request. Power-down is sampled inside the cycle of each data, status or reset access, so a registered exit would show one cycle too late. Bit 5 writes, the off code 3'b111 and the rate-dependent default under 1 Mbps and 500 kbps are checked against pc_step_o, to expose a wrong default or a decoder that reads bit 5.

// File: rtl/fdc_rate_pkg.sv
`timescale 1ns/1ps
package fdc_rate_pkg;
  localparam int RATE_W = 2;
  localparam int PC_W   = 3;
  localparam int DATA_W = 8;

  typedef enum logic [RATE_W-1:0] {
    RATE_500K = 2'b00,
    RATE_300K = 2'b01,
    RATE_250K = 2'b10,
    RATE_1M   = 2'b11
  } rate_e;

  localparam logic [PC_W-1:0] PC_DEFAULT = 3'b000;
  localparam logic [PC_W-1:0] PC_OFF     = 3'b111;

  // default delay in 41.67 ns steps
  function automatic logic [PC_W-1:0] pc_default_step(rate_e r);
    return (r == RATE_1M) ? PC_W'(1) : PC_W'(3);
  endfunction
endpackage

// File: rtl/fdc_rate_store.sv
`timescale 1ns/1ps
module fdc_rate_store
  import fdc_rate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dsr_we_i,
  input  logic              ccr_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output rate_e             rate_o,
  output logic [PC_W-1:0]   pc_code_o
);
  localparam int PC_LSB = RATE_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_o    <= RATE_250K;
      pc_code_o <= PC_DEFAULT;
    end else if (dsr_we_i) begin
      rate_o    <= rate_e'(wdata_i[RATE_W-1:0]);
      pc_code_o <= wdata_i[PC_LSB +: PC_W];
    end else if (ccr_we_i) begin
      rate_o    <= rate_e'(wdata_i[RATE_W-1:0]);
    end
  end
endmodule

// File: rtl/fdc_lowpwr.sv
`timescale 1ns/1ps
module fdc_lowpwr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dsr_we_i,
  input  logic lp_req_i,
  input  logic srst_req_i,
  input  logic data_acc_i,
  input  logic stat_acc_i,
  output logic pwr_down_o,
  output logic sw_rst_o
);
  logic lp_q, srst_now, wake;

  assign srst_now = dsr_we_i & srst_req_i;
  assign wake     = data_acc_i | stat_acc_i | srst_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lp_q     <= 1'b0;
      sw_rst_o <= 1'b0;
    end else begin
      sw_rst_o <= srst_now;
      if (wake)                      lp_q <= 1'b0;
      else if (dsr_we_i && lp_req_i) lp_q <= 1'b1;
    end
  end

  // exit is combinational so a status read is not held off
  assign pwr_down_o = lp_q & ~wake;
endmodule

// File: rtl/fdc_precomp_map.sv
`timescale 1ns/1ps
module fdc_precomp_map
  import fdc_rate_pkg::*;
(
  input  rate_e           rate_i,
  input  logic [PC_W-1:0] code_i,
  output logic [PC_W-1:0] step_o
);
  always_comb begin
    unique case (code_i)
      PC_OFF:     step_o = '0;
      PC_DEFAULT: step_o = pc_default_step(rate_i);
      default:    step_o = code_i;
    endcase
  end
endmodule

// File: rtl/fdc_rate_reg.sv
`timescale 1ns/1ps
module fdc_rate_reg
  import fdc_rate_pkg::*;
#(
  parameter int                ADDR_W  = 3,
  parameter logic [ADDR_W-1:0] DSR_OFS = 3'd4,
  parameter logic [ADDR_W-1:0] CCR_OFS = 3'd7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              data_acc_i,
  input  logic              stat_acc_i,
  output logic [RATE_W-1:0] rate_o,
  output logic [PC_W-1:0]   precomp_o,
  output logic [PC_W-1:0]   pc_step_o,
  output logic              pwr_down_o,
  output logic              sw_rst_o
);
  localparam int LP_BIT   = 6;
  localparam int SRST_BIT = 7;

  logic  dsr_we, ccr_we;
  rate_e rate_q;

  assign dsr_we = wr_en_i && (addr_i == DSR_OFS);
  assign ccr_we = wr_en_i && (addr_i == CCR_OFS);

  fdc_rate_store u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dsr_we_i  (dsr_we),
    .ccr_we_i  (ccr_we),
    .wdata_i   (wdata_i),
    .rate_o    (rate_q),
    .pc_code_o (precomp_o)
  );

  fdc_lowpwr u_lowpwr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dsr_we_i   (dsr_we),
    .lp_req_i   (wdata_i[LP_BIT]),
    .srst_req_i (wdata_i[SRST_BIT]),
    .data_acc_i (data_acc_i),
    .stat_acc_i (stat_acc_i),
    .pwr_down_o (pwr_down_o),
    .sw_rst_o   (sw_rst_o)
  );

  fdc_precomp_map u_map (
    .rate_i (rate_q),
    .code_i (precomp_o),
    .step_o (pc_step_o)
  );

  assign rate_o = rate_q;
endmodule

// File: rtl/fdc_rate_reg_chk.sv
`timescale 1ns/1ps
module fdc_rate_reg_chk #(
  parameter int                ADDR_W  = 3,
  parameter logic [ADDR_W-1:0] DSR_OFS = 3'd4,
  parameter logic [ADDR_W-1:0] CCR_OFS = 3'd7
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        wdata_i,
  input logic              data_acc_i,
  input logic              stat_acc_i,
  input logic [1:0]        rate_o,
  input logic [2:0]        precomp_o,
  input logic [2:0]        pc_step_o,
  input logic              pwr_down_o,
  input logic              sw_rst_o
);
  logic dsr_w, ccr_w, rst_w;
  assign dsr_w = wr_en_i && (addr_i == DSR_OFS);
  assign ccr_w = wr_en_i && (addr_i == CCR_OFS);
  assign rst_w = dsr_w && wdata_i[7];

  // R5
  srst_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_w |=> sw_rst_o);
  // R5
  srst_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_rst_o && !rst_w) |=> !sw_rst_o);
  // R3
  ccr_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ccr_w |=> (rate_o == $past(wdata_i[1:0]) && $stable(precomp_o)));
  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dsr_w || ccr_w) |=> ($stable(rate_o) && $stable(precomp_o)));
  // R7
  wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_acc_i || stat_acc_i) |-> !pwr_down_o);
  // R6
  lp_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsr_w && wdata_i[6] && !wdata_i[7] && !data_acc_i && !stat_acc_i)
      |=> (pwr_down_o || data_acc_i || stat_acc_i || rst_w));
  // R8
  srst_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_w |-> !pwr_down_o);
  // R9
  pc_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (precomp_o == 3'b111) |-> (pc_step_o == 3'd0));
endmodule

bind fdc_rate_reg fdc_rate_reg_chk #(
  .ADDR_W (ADDR_W), .DSR_OFS (DSR_OFS), .CCR_OFS (CCR_OFS)
) u_chk (
  .clk_i (clk_i), .rst_ni (rst_ni), .wr_en_i (wr_en_i), .addr_i (addr_i),
  .wdata_i (wdata_i), .data_acc_i (data_acc_i), .stat_acc_i (stat_acc_i),
  .rate_o (rate_o), .precomp_o (precomp_o), .pc_step_o (pc_step_o),
  .pwr_down_o (pwr_down_o), .sw_rst_o (sw_rst_o)
);

// File: tb/test_fdc_rate_reg.sv
`timescale 1ns/1ps
module test_fdc_rate_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       dacc = 1'b0, sacc = 1'b0;
  logic [1:0] rate;
  logic [2:0] pc, step;
  logic       pd, sr;

  int checks = 0, errors = 0;

  typedef struct {
    logic [1:0] r; logic [2:0] p; logic [2:0] s; logic pd; logic sr; string tag;
  } exp_t;
  exp_t q[$];

  logic [1:0] m_rate = 2'b10;
  logic [2:0] m_pc = 3'b000;
  logic       m_lp = 1'b0;

  always #10 clk = ~clk;

  fdc_rate_reg i_fdc_rate_reg (
    .clk_i (clk), .rst_ni (rst_n), .wr_en_i (wr_en), .addr_i (addr),
    .wdata_i (wdata), .data_acc_i (dacc), .stat_acc_i (sacc),
    .rate_o (rate), .precomp_o (pc), .pc_step_o (step),
    .pwr_down_o (pd), .sw_rst_o (sr)
  );

  function automatic logic [2:0] exp_step(logic [1:0] r, logic [2:0] c);
    if (c == 3'b111) return 3'd0;
    if (c == 3'b000) return (r == 2'b11) ? 3'd1 : 3'd3;
    return c;
  endfunction

  task automatic cmp(exp_t e);
    checks++;
    if (rate !== e.r || pc !== e.p || step !== e.s || pd !== e.pd || sr !== e.sr) begin
      errors++;
      $display("FAIL %s: got rate=%b pc=%b step=%0d pd=%b sr=%b exp rate=%b pc=%b step=%0d pd=%b sr=%b",
               e.tag, rate, pc, step, pd, sr, e.r, e.p, e.s, e.pd, e.sr);
    end
  endtask

  // driver: one host cycle, model update, expected item pushed
  task automatic op(input logic we, input logic [2:0] a, input logic [7:0] d,
                    input logic da, input logic sa, input string tag);
    logic dsr, ccr, wake, lp_before;
    exp_t e;
    @(negedge clk);
    wr_en = we; addr = a; wdata = d; dacc = da; sacc = sa;
    dsr  = we && (a == 3'd4);
    ccr  = we && (a == 3'd7);
    wake = da | sa | (dsr & d[7]);
    lp_before = m_lp;
    #1;
    if (lp_before) begin
      checks++;
      if (pd !== !wake) begin
        errors++;
        $display("FAIL %s same-cycle pwr_down (R6/R7/R8): got %b exp %b", tag, pd, !wake);
      end
    end
    if (dsr) begin m_rate = d[1:0]; m_pc = d[4:2]; end
    else if (ccr) m_rate = d[1:0];
    if (wake) m_lp = 1'b0;
    else if (dsr && d[6]) m_lp = 1'b1;
    e.r = m_rate; e.p = m_pc; e.s = exp_step(m_rate, m_pc);
    e.pd = m_lp; e.sr = dsr & d[7]; e.tag = tag;
    q.push_back(e);
    @(posedge clk);
    #1;
    wr_en = 1'b0; dacc = 1'b0; sacc = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) cmp(q.pop_front());
    end
  end

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    exp_t r0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    r0.r = 2'b10; r0.p = 3'b000; r0.s = 3'd3; r0.pd = 1'b0; r0.sr = 1'b0; r0.tag = "R1 reset";
    cmp(r0);

    op(1, 3'd4, 8'h00, 0, 0, "R2 rate500 default pc");
    op(1, 3'd4, 8'h15, 0, 0, "R2 R9 pc101");
    op(1, 3'd4, 8'h1F, 0, 0, "R9 pc off at 1M");
    op(1, 3'd4, 8'h03, 0, 0, "R9 default at 1M");
    op(1, 3'd7, 8'h00, 0, 0, "R3 ccr rate only");
    op(1, 3'd4, 8'h2E, 0, 0, "R10 bit5 ignored");
    op(1, 3'd4, 8'h0E, 0, 0, "R10 same without bit5");
    op(0, 3'd4, 8'hFF, 0, 0, "R4 no strobe");
    op(1, 3'd5, 8'hFF, 0, 0, "R4 other offset");
    op(1, 3'd7, 8'h01, 0, 0, "R3 ccr last");
    op(1, 3'd4, 8'h02, 0, 0, "R3 dsr last");
    op(1, 3'd4, 8'h8D, 0, 0, "R5 sw reset pulse");
    op(0, 3'd0, 8'h00, 0, 0, "R5 pulse ends");
    op(1, 3'd4, 8'h40, 0, 0, "R6 enter low power");
    op(0, 3'd0, 8'h00, 0, 0, "R6 holds");
    op(1, 3'd4, 8'h01, 0, 0, "R6 bit6 clear keeps");
    op(1, 3'd7, 8'h03, 0, 0, "R6 ccr keeps");
    op(0, 3'd0, 8'h00, 1, 0, "R7 data access exit");
    op(0, 3'd0, 8'h00, 0, 0, "R7 stays out");
    op(1, 3'd4, 8'h44, 0, 0, "R6 enter again");
    op(0, 3'd0, 8'h00, 0, 1, "R7 status access exit");
    op(1, 3'd4, 8'h40, 0, 0, "R6 enter third");
    op(1, 3'd4, 8'h80, 0, 0, "R8 sw reset exit");
    op(1, 3'd4, 8'hC0, 0, 0, "R8 bit6 with bit7");
    op(0, 3'd0, 8'h00, 0, 0, "R8 no entry");
    op(1, 3'd4, 8'h40, 1, 0, "R8 access beats entry");
    op(0, 3'd0, 8'h00, 0, 0, "R8 still out");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule